// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block turns the 16-bit address of an 8-bit processor into chip selects for a 128K static RAM, a flash ROM, a serial communications controller, a parallel interface adapter and a write-only mailbox port to an I/O coprocessor. The map is uneven. The low 40K is RAM, a 4K page at `$A000` holds the peripherals, and the top 20K is ROM. Inside the I/O page each device gets its own 16-byte slot. The mailbox answers at one exact address. All decode is combinational, so a fast bus needs no wait states.

The 8K RAM window at `$8000–$9FFF` is banked. A 3-bit bank value is held in an external register driven by a parallel port. That value sets the upper physical RAM address lines, which moves the window across the part of the 128K device above the fixed low 32K. Read and write strobes are gated by the high phase of the bus clock. A byte written to the mailbox is held in a latch, and a ready flag stays set until the coprocessor acknowledges it.

Top module: `bankdec_top`

## Requirements
- R1: `ram_sel` is 1 exactly for `cpu_addr` in `$0000–$9FFF`.
- R2: `rom_sel` is 1 exactly for `cpu_addr` in `$B000–$FFFF`.
- R3: In the I/O page `$A000–$AFFF`, `acia_sel` is 1 exactly for `$A010–$A01F`, `via_sel` is 1 exactly for `$A020–$A02F`, and `mbox_sel` is 1 only for `$A800`. Any other I/O address raises no select.
- R4: At most one of the five selects is 1 for any address and bank value.
- R5: For any address outside `$8000–$9FFF`, `sram_addr` is `{1'b0, cpu_addr}`, so `$0000–$7FFF` reach physical `$00000–$07FFF`.
- R6: For `cpu_addr` in `$8000–$9FFF`, `sram_addr` is `$08000 + bank_sel*$2000 + cpu_addr[12:0]`. Bank 0 therefore gives physical `$08000–$09FFF`, and bank 7 gives `$16000–$17FFF`.
- R7: `ram_we` is 1 only while `clk` is high, `ram_sel` is 1 and `cpu_rw` is 0 (write). `ram_oe` is 1 only while `clk` is high, `ram_sel` is 1 and `cpu_rw` is 1 (read).
- R8: A write to the ROM region has no effect. `rom_oe` is 1 only on reads (`cpu_rw`=1) with `clk` high and `rom_sel` set, and such a write raises neither `ram_we` nor `rom_oe`.
- R9: `data_oe` is 1 only while `clk` is high on a read that selects the RAM, the ROM, the serial controller or the interface adapter. It stays 0 on reads of unmatched I/O addresses and of the mailbox address.
- R10: On a rising `clk` edge where `cpu_addr`=`$A800` and `cpu_rw`=0, `cpu_wdata` is latched onto `mbox_data` and `mbox_ready` becomes 1. Writes to any other address leave `mbox_data` unchanged.
- R11: `mbox_ready` stays 1 until a rising edge with `mbox_ack`=1 and no mailbox write, which clears it. A mailbox write in the same cycle as `mbox_ack` wins and leaves `mbox_ready` at 1.
- R12: While `rst_n` is 0, `mbox_ready` is 0 and `mbox_data` is `$00`. Reset asserts asynchronously and is released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; high phase qualifies strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Processor write data |
| bank_sel | input | 3 | Registered bank number from the parallel port |
| mbox_ack | input | 1 | Coprocessor acknowledge; clears the ready flag |
| ram_sel | output | 1 | SRAM chip select |
| rom_sel | output | 1 | Flash ROM chip select |
| acia_sel | output | 1 | Serial controller select |
| via_sel | output | 1 | Interface adapter select |
| mbox_sel | output | 1 | Mailbox port select |
| sram_addr | output | 17 | Physical SRAM address |
| ram_we | output | 1 | Qualified SRAM write strobe |
| ram_oe | output | 1 | Qualified SRAM read strobe |
| rom_oe | output | 1 | Qualified ROM read strobe |
| data_oe | output | 1 | A selected device drives the read data bus |
| mbox_data | output | 8 | Latched mailbox byte |
| mbox_ready | output | 1 | Mailbox holds an unacknowledged byte |

## Verification
The assertions assume that address, direction, write data, bank number and acknowledge settle during the low clock phase and stay steady through the following high phase and rising edge. The strobe properties are sampled at the falling edge, while the clock is still high. The mailbox properties are sampled at the rising edge. The bench changes every input just after a falling edge, so each rising edge sees settled values. Its exhaustive address sweep holds the direction at read and the acknowledge low, so the sweep never disturbs the mailbox.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  localparam int ADDR_W   = 16;
  localparam int PHYS_W   = 17;
  localparam int BANK_W   = 3;
  localparam int DATA_W   = 8;
  localparam int WIN_BITS = 13;
  localparam int SLOT_BITS = 4;
  localparam int IO_DEV_N = 2;

  localparam logic [ADDR_W-1:0] IO_BASE   = 16'hA000;
  localparam logic [ADDR_W-1:0] ROM_BASE  = 16'hB000;
  localparam logic [ADDR_W-1:0] WIN_BASE  = 16'h8000;
  localparam logic [ADDR_W-1:0] MBOX_ADDR = 16'hA800;
  // slot bases, index 0 = serial controller, index 1 = interface adapter
  localparam logic [IO_DEV_N*ADDR_W-1:0] IO_SLOTS = {16'hA020, 16'hA010};

  typedef struct packed {
    logic mbox;
    logic via;
    logic acia;
    logic rom;
    logic ram;
  } sel_t;
endpackage

// File: rtl/bankdec_region.sv
module bankdec_region
  import bankdec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  logic [IO_DEV_N-1:0] slot_hit;

  genvar i;
  generate
    for (i = 0; i < IO_DEV_N; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] BASE = IO_SLOTS[i*ADDR_W +: ADDR_W];
      assign slot_hit[i] = (addr[ADDR_W-1:SLOT_BITS] == BASE[ADDR_W-1:SLOT_BITS]);
    end
  endgenerate

  always_comb begin
    sel      = '0;
    sel.ram  = (addr < IO_BASE);
    sel.rom  = (addr >= ROM_BASE);
    sel.acia = slot_hit[0];
    sel.via  = slot_hit[1];
    sel.mbox = (addr == MBOX_ADDR);
  end
endmodule

// File: rtl/bankdec_bank_map.sv
module bankdec_bank_map
  import bankdec_pkg::*;
#(
  parameter int BW = BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     bank,
  output logic [PHYS_W-1:0] phys
);
  localparam logic [PHYS_W-1:0] WIN_PHYS = PHYS_W'(WIN_BASE);

  logic              in_win;
  logic [PHYS_W-1:0] bank_base;

  assign in_win    = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
  assign bank_base = WIN_PHYS + (PHYS_W'(bank) << WIN_BITS);

  always_comb begin
    if (in_win) phys = bank_base + PHYS_W'(addr[WIN_BITS-1:0]);
    else        phys = PHYS_W'(addr);
  end
endmodule

// File: rtl/bankdec_strobe.sv
module bankdec_strobe
  import bankdec_pkg::*;
(
  input  logic phase_hi,
  input  logic rw,
  input  sel_t sel,
  output logic ram_we,
  output logic ram_oe,
  output logic rom_oe,
  output logic data_oe
);
  logic rd_hi, wr_hi;

  assign rd_hi   = phase_hi & rw;
  assign wr_hi   = phase_hi & ~rw;
  assign ram_we  = wr_hi & sel.ram;
  assign ram_oe  = rd_hi & sel.ram;
  assign rom_oe  = rd_hi & sel.rom;
  assign data_oe = rd_hi & (sel.ram | sel.rom | sel.acia | sel.via);
endmodule

// File: rtl/bankdec_mailbox.sv
module bankdec_mailbox #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  output logic [DW-1:0] data,
  output logic          ready
);
  logic [DW-1:0] data_q, data_d;
  logic          rdy_q, rdy_d;
  logic          wr_hit, data_en;

  assign wr_hit = hit & wr;

  always_comb begin
    data_en = wr_hit;
    data_d  = wdata;
    rdy_d   = rdy_q;
    if (wr_hit)   rdy_d = 1'b1;
    else if (ack) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      rdy_q <= rdy_d;
    end
  end

  assign data  = data_q;
  assign ready = rdy_q;

  assert_ready_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(wr_hit));
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(data_q));
  assert_ready_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !ack) |=> rdy_q);
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> rdy_q);
endmodule

// File: rtl/bankdec_top.sv
module bankdec_top
  import bankdec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic [BW-1:0]     bank_sel,
  input  logic              mbox_ack,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic              acia_sel,
  output logic              via_sel,
  output logic              mbox_sel,
  output logic [PHYS_W-1:0] sram_addr,
  output logic              ram_we,
  output logic              ram_oe,
  output logic              rom_oe,
  output logic              data_oe,
  output logic [DW-1:0]     mbox_data,
  output logic              mbox_ready
);
  sel_t       sel;
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  // asynchronous assertion, release after two rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  bankdec_region u_region (
    .addr (cpu_addr),
    .sel  (sel)
  );

  bankdec_bank_map #(.BW(BW)) u_bank_map (
    .addr (cpu_addr),
    .bank (bank_sel),
    .phys (sram_addr)
  );

  bankdec_strobe u_strobe (
    .phase_hi (clk),
    .rw       (cpu_rw),
    .sel      (sel),
    .ram_we   (ram_we),
    .ram_oe   (ram_oe),
    .rom_oe   (rom_oe),
    .data_oe  (data_oe)
  );

  bankdec_mailbox #(.DW(DW)) u_mailbox (
    .clk   (clk),
    .rst_n (rst_int_n),
    .hit   (sel.mbox),
    .wr    (~cpu_rw),
    .wdata (cpu_wdata),
    .ack   (mbox_ack),
    .data  (mbox_data),
    .ready (mbox_ready)
  );

  assign ram_sel  = sel.ram;
  assign rom_sel  = sel.rom;
  assign acia_sel = sel.acia;
  assign via_sel  = sel.via;
  assign mbox_sel = sel.mbox;

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, rom_sel, acia_sel, via_sel, mbox_sel}));
  assert_low_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h8000) |-> (sram_addr < 17'h08000));
  assert_window_phys_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b100) |-> (sram_addr >= 17'h08000 && sram_addr < 17'h18000));
  assert_we_scope_R7: assert property (@(negedge clk) disable iff (!rst_n)
    ram_we |-> (!cpu_rw && cpu_addr < 16'hA000));
  assert_rom_read_only_R8: assert property (@(negedge clk) disable iff (!rst_n)
    rom_oe |-> (cpu_rw && cpu_addr >= 16'hB000));
  assert_drive_scope_R9: assert property (@(negedge clk) disable iff (!rst_n)
    data_oe |-> (cpu_rw && !mbox_sel && (ram_sel || rom_sel || acia_sel || via_sel)));
endmodule

// File: tb/bankdec_top_tb.sv
module bankdec_top_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rw;
  logic [7:0]  cpu_wdata;
  logic [2:0]  bank_sel;
  logic        mbox_ack;
  logic        ram_sel, rom_sel, acia_sel, via_sel, mbox_sel;
  logic [16:0] sram_addr;
  logic        ram_we, ram_oe, rom_oe, data_oe;
  logic [7:0]  mbox_data;
  logic        mbox_ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] m_data;
  logic       m_ready;

  bankdec_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_wdata(cpu_wdata), .bank_sel(bank_sel), .mbox_ack(mbox_ack),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .acia_sel(acia_sel), .via_sel(via_sel),
    .mbox_sel(mbox_sel), .sram_addr(sram_addr), .ram_we(ram_we), .ram_oe(ram_oe),
    .rom_oe(rom_oe), .data_oe(data_oe), .mbox_data(mbox_data), .mbox_ready(mbox_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {mbox, via, acia, rom, ram}
  function automatic logic [4:0] exp_sel(input logic [15:0] a);
    logic [4:0] s;
    s[0] = (a <= 16'h9FFF);
    s[1] = (a >= 16'hB000);
    s[2] = (a >= 16'hA010 && a <= 16'hA01F);
    s[3] = (a >= 16'hA020 && a <= 16'hA02F);
    s[4] = (a == 16'hA800);
    return s;
  endfunction

  function automatic logic [16:0] exp_phys(input logic [15:0] a, input logic [2:0] b);
    if (a >= 16'h8000 && a <= 16'h9FFF)
      return 17'h08000 + 17'(b) * 17'd8192 + 17'(a & 16'h1FFF);
    return {1'b0, a};
  endfunction

  task automatic chk_strobes(input string ph);
    logic [4:0] s;
    logic hi;
    s  = exp_sel(cpu_addr);
    hi = clk;
    chk(ram_we == (s[0] & ~cpu_rw & hi), "R7", {"ram_we ", ph}, 32'(ram_we), 32'(s[0] & ~cpu_rw & hi));
    chk(ram_oe == (s[0] & cpu_rw & hi), "R7", {"ram_oe ", ph}, 32'(ram_oe), 32'(s[0] & cpu_rw & hi));
    chk(rom_oe == (s[1] & cpu_rw & hi), "R8", {"rom_oe ", ph}, 32'(rom_oe), 32'(s[1] & cpu_rw & hi));
    chk(data_oe == (cpu_rw & hi & (|s[3:0])), "R9", {"data_oe ", ph}, 32'(data_oe),
        32'(cpu_rw & hi & (|s[3:0])));
  endtask

  // one bus cycle: inputs change after the falling edge, capture at the rising edge
  task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic [7:0] d,
                           input logic [2:0] b, input logic ack);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_wdata = d; bank_sel = b; mbox_ack = ack;
    #2;
    chk_strobes("low");
    @(posedge clk);
    if (a == 16'hA800 && !rw) begin m_data = d; m_ready = 1'b1; end
    else if (ack) m_ready = 1'b0;
    #2;
    chk_strobes("high");
    chk(mbox_data == m_data, "R10", "mbox_data", 32'(mbox_data), 32'(m_data));
    chk(mbox_ready == m_ready, "R11", "mbox_ready", 32'(mbox_ready), 32'(m_ready));
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 7)
      0: return 16'hA800;
      1: return 16'hA010 | 16'($urandom % 16);
      2: return 16'hA020 | 16'($urandom % 16);
      3: return 16'hA000 | 16'($urandom % 4096);
      4: return 16'h8000 | 16'($urandom % 8192);
      5: return 16'hB000 + 16'($urandom % 20480);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    int unsigned seed_init;
    logic [4:0] s;
    seed_init = $urandom(32'd51966);
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_rw = 1'b1; cpu_wdata = 8'h00;
    bank_sel = 3'd0; mbox_ack = 1'b0;
    m_data = 8'h00; m_ready = 1'b0;

    repeat (3) @(negedge clk);
    // R12: reset state
    chk(mbox_ready == 1'b0, "R12", "mbox_ready in reset", 32'(mbox_ready), 0);
    chk(mbox_data == 8'h00, "R12", "mbox_data in reset", 32'(mbox_data), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) bus_cycle(16'h0000, 1'b1, 8'h00, 3'd0, 1'b0);

    // exhaustive sweep of addresses for every bank value
    for (int b = 0; b < 8; b++) begin
      for (int a = 0; a < 65536; a++) begin
        cpu_addr = 16'(a); bank_sel = 3'(b);
        #1;
        s = exp_sel(16'(a));
        chk(ram_sel == s[0], "R1", "ram_sel", 32'(a), 32'(s[0]));
        chk(rom_sel == s[1], "R2", "rom_sel", 32'(a), 32'(s[1]));
        chk({mbox_sel, via_sel, acia_sel} == s[4:2], "R3", "io selects",
            32'({mbox_sel, via_sel, acia_sel}), 32'(s[4:2]));
        chk($countones({ram_sel, rom_sel, acia_sel, via_sel, mbox_sel}) <= 1, "R4",
            "select count", 32'($countones({ram_sel, rom_sel, acia_sel, via_sel, mbox_sel})), 1);
        if (a >= 16'h8000 && a <= 16'h9FFF)
          chk(sram_addr == exp_phys(16'(a), 3'(b)), "R6", "window sram_addr",
              32'(sram_addr), 32'(exp_phys(16'(a), 3'(b))));
        else
          chk(sram_addr == exp_phys(16'(a), 3'(b)), "R5", "fixed sram_addr",
              32'(sram_addr), 32'(exp_phys(16'(a), 3'(b))));
      end
    end

    // directed corners
    bus_cycle(16'hA800, 1'b0, 8'h5A, 3'd2, 1'b0);   // R10 capture
    for (int k = 0; k < 3; k++) bus_cycle(16'h1234, 1'b1, 8'hEE, 3'd2, 1'b0); // R11 hold
    bus_cycle(16'hA801, 1'b0, 8'hFF, 3'd2, 1'b0);   // R10 neighbour write ignored
    bus_cycle(16'hA800, 1'b1, 8'h77, 3'd2, 1'b0);   // R9 mailbox read not driven
    bus_cycle(16'h0000, 1'b1, 8'h00, 3'd0, 1'b1);   // R11 ack clears
    bus_cycle(16'hA800, 1'b0, 8'h33, 3'd0, 1'b1);   // R11 write beats ack
    bus_cycle(16'hC000, 1'b0, 8'hAA, 3'd7, 1'b0);   // R8 ROM write ignored
    bus_cycle(16'hA100, 1'b1, 8'h00, 3'd7, 1'b0);   // R9 unmatched I/O read
    bus_cycle(16'h9FFF, 1'b0, 8'h01, 3'd7, 1'b0);   // R7 banked write strobe
    bus_cycle(16'hA02F, 1'b1, 8'h00, 3'd1, 1'b0);   // R9 adapter read driven

    // constrained random traffic
    for (int k = 0; k < 3000; k++)
      bus_cycle(pick_addr(), 1'($urandom % 2), 8'($urandom), 3'($urandom),
                1'(($urandom % 4) == 0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule